// File: doc/BRIEF.md
# Latched Three-Port Bus Multiplexer

This block connects two independent 16-bit buses, A and B, to one shared bus, AB. Toward AB, each of A and B has its own storage stage. A select input decides which of the two stored words appears on AB. Away from AB, the AB input feeds two more storage stages: one returns data to A and the other returns data to B. Each stage has its own active-low enable. While the enable is low the stage follows its input. Once the enable is high the stage keeps the last word it took in.

Each port is modelled as three things: an input word, an output word, and a pair of active-low byte enables. The block turns the byte enables into active-high drive flags, so a pad wrapper can build real tristate pins from them. A build parameter chooses between a data path that inverts on every transfer and one that passes data unchanged.

The design is built for FPGA fabric, so each storage stage is a clocked register with a synchronous active-high reset. "Transparent" therefore means the stage reloads on every clock edge at which its enable is low. Any stage change is visible at the outputs one clock later.

Top module: `bmx_three_port`

## Requirements
- R1: A synchronous reset clears all four storage stages. In the clock after reset, a_out, b_out and ab_out all equal the inversion mask: 0x0000 when INVERT=0, 0xFFFF when INVERT=1.
- R2: At each clock edge where an outbound enable (a_le_n or b_le_n) is low, that stage loads its bus input. One clock later the loaded word reaches ab_out if its side is selected.
- R3: While an enable is high its stage keeps the word from the last edge at which the enable was low. Changes on that stage's input have no effect on the outputs.
- R4: sel_b = 0 routes the A-side stage to ab_out and sel_b = 1 routes the B-side stage. The choice acts in the same cycle, with no clock between.
- R5: At each clock edge where aba_le_n is low, the A-return stage loads ab_in and drives a_out. At each edge where abb_le_n is low, the B-return stage loads ab_in and drives b_out.
- R6: For every port, byte lane 0 is bits 7..0 and lane 1 is bits 15..8. Drive flag bit k is high exactly when oe_n bit k is low. Each lane is independent of the other and of the other ports.
- R7: With INVERT=1 every transfer between ports delivers the bitwise complement. With INVERT=0 it delivers the word unchanged.
- R8: The four stages are independent. Loading any one stage leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_b | input | 1 | 0 selects the A-side stage onto AB, 1 selects the B-side stage |
| a_le_n | input | 1 | Active-low load enable, A input toward AB |
| b_le_n | input | 1 | Active-low load enable, B input toward AB |
| aba_le_n | input | 1 | Active-low load enable, AB input toward A |
| abb_le_n | input | 1 | Active-low load enable, AB input toward B |
| a_in | input | 16 | Word received on bus A |
| b_in | input | 16 | Word received on bus B |
| ab_in | input | 16 | Word received on bus AB |
| a_oe_n | input | 2 | Active-low byte drive enables for bus A |
| b_oe_n | input | 2 | Active-low byte drive enables for bus B |
| ab_oe_n | input | 2 | Active-low byte drive enables for bus AB |
| a_out | output | 16 | Word to drive on bus A |
| b_out | output | 16 | Word to drive on bus B |
| ab_out | output | 16 | Word to drive on bus AB |
| a_drv | output | 2 | Active-high byte drive flags for bus A |
| b_drv | output | 2 | Active-high byte drive flags for bus B |
| ab_drv | output | 2 | Active-high byte drive flags for bus AB |

## Verification
The bench builds two copies of the block with the default 16-bit width and 8-bit lanes, one with INVERT=0 and one with INVERT=1. Both copies share the same stimulus, so every check compares straight and complemented results on identical data. The sweep runs every combination of the four load enables with both select values, so each stage is loaded, held and routed in all pairings with the others. A separate loop covers all 64 patterns of the six byte enables.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  function automatic logic [DATA_W-1:0] pol_apply(input logic [DATA_W-1:0] w, input bit inv);
    return w ^ {DATA_W{inv}};
  endfunction
endpackage

// File: rtl/bmx_stage.sv
module bmx_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Clocked equivalent of a transparent-low latch: reload while enabled, keep otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (!le_n) begin
      q <= d;
    end
  end
endmodule

// File: rtl/bmx_port_drive.sv
module bmx_port_drive #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE   = 8,
  parameter bit          INVERT = 1'b0,
  localparam int unsigned LANES = W / LANE
) (
  input  logic [W-1:0]     word_i,
  input  logic [LANES-1:0] oe_n,
  output logic [W-1:0]     word_o,
  output logic [LANES-1:0] drv
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_o[k*LANE +: LANE] = word_i[k*LANE +: LANE] ^ {LANE{INVERT}};
    assign drv[k]                 = ~oe_n[k];
  end
endmodule

// File: rtl/bmx_three_port.sv
module bmx_three_port
  import bmx_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned LANE   = LANE_W,
  parameter bit          INVERT = 1'b0,
  localparam int unsigned LANES = W / LANE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_b,
  input  logic             a_le_n,
  input  logic             b_le_n,
  input  logic             aba_le_n,
  input  logic             abb_le_n,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [W-1:0]     ab_in,
  input  logic [LANES-1:0] a_oe_n,
  input  logic [LANES-1:0] b_oe_n,
  input  logic [LANES-1:0] ab_oe_n,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     ab_out,
  output logic [LANES-1:0] a_drv,
  output logic [LANES-1:0] b_drv,
  output logic [LANES-1:0] ab_drv
);
  logic [W-1:0] a_hold, b_hold, ba_hold, bb_hold, ab_pick;
  src_e         src;

  bmx_stage #(.W(W)) u_st_a  (.clk(clk), .rst(rst), .le_n(a_le_n),   .d(a_in),  .q(a_hold));
  bmx_stage #(.W(W)) u_st_b  (.clk(clk), .rst(rst), .le_n(b_le_n),   .d(b_in),  .q(b_hold));
  bmx_stage #(.W(W)) u_st_ba (.clk(clk), .rst(rst), .le_n(aba_le_n), .d(ab_in), .q(ba_hold));
  bmx_stage #(.W(W)) u_st_bb (.clk(clk), .rst(rst), .le_n(abb_le_n), .d(ab_in), .q(bb_hold));

  assign src = src_e'(sel_b);

  always_comb begin
    unique case (src)
      SRC_B:   ab_pick = b_hold;
      default: ab_pick = a_hold;
    endcase
  end

  bmx_port_drive #(.W(W), .LANE(LANE), .INVERT(INVERT)) u_drv_ab
    (.word_i(ab_pick), .oe_n(ab_oe_n), .word_o(ab_out), .drv(ab_drv));
  bmx_port_drive #(.W(W), .LANE(LANE), .INVERT(INVERT)) u_drv_a
    (.word_i(ba_hold), .oe_n(a_oe_n), .word_o(a_out), .drv(a_drv));
  bmx_port_drive #(.W(W), .LANE(LANE), .INVERT(INVERT)) u_drv_b
    (.word_i(bb_hold), .oe_n(b_oe_n), .word_o(b_out), .drv(b_drv));
endmodule

// File: rtl/bmx_three_port_chk.sv
module bmx_three_port_chk #(
  parameter int unsigned W      = 16,
  parameter bit          INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_b,
  input logic         a_le_n,
  input logic         b_le_n,
  input logic         aba_le_n,
  input logic         abb_le_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] ab_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic [W-1:0] ab_out
);
  localparam logic [W-1:0] MASK = {W{INVERT}};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (a_out == MASK && b_out == MASK && ab_out == MASK));

  p_a_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !a_le_n |=> (sel_b || ab_out == ($past(a_in) ^ MASK)));

  p_b_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !b_le_n |=> (!sel_b || ab_out == ($past(b_in) ^ MASK)));

  p_a_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (a_le_n && !sel_b) |=> (sel_b || $stable(ab_out)));

  p_ret_a_r5: assert property (@(posedge clk) disable iff (rst)
    !aba_le_n |=> (a_out == ($past(ab_in) ^ MASK)));

  p_ret_b_hold_r8: assert property (@(posedge clk) disable iff (rst)
    abb_le_n |=> $stable(b_out));
endmodule

bind bmx_three_port bmx_three_port_chk #(.W(W), .INVERT(INVERT)) u_chk (.*);

// File: tb/sim_bmx_three_port.sv
module sim_bmx_three_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_b = 1'b0;
  logic a_le_n = 1'b1, b_le_n = 1'b1, aba_le_n = 1'b1, abb_le_n = 1'b1;
  logic [15:0] a_in = '0, b_in = '0, ab_in = '0;
  logic [1:0]  a_oe_n = 2'b11, b_oe_n = 2'b11, ab_oe_n = 2'b11;
  logic [15:0] a_out0, b_out0, ab_out0, a_out1, b_out1, ab_out1;
  logic [1:0]  a_drv0, b_drv0, ab_drv0, a_drv1, b_drv1, ab_drv1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] m_a, m_b, m_ba, m_bb;

  always #10 clk = ~clk;

  bmx_three_port #(.INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .sel_b(sel_b), .a_le_n(a_le_n), .b_le_n(b_le_n),
    .aba_le_n(aba_le_n), .abb_le_n(abb_le_n), .a_in(a_in), .b_in(b_in), .ab_in(ab_in),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .ab_oe_n(ab_oe_n),
    .a_out(a_out0), .b_out(b_out0), .ab_out(ab_out0),
    .a_drv(a_drv0), .b_drv(b_drv0), .ab_drv(ab_drv0));

  bmx_three_port #(.INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .sel_b(sel_b), .a_le_n(a_le_n), .b_le_n(b_le_n),
    .aba_le_n(aba_le_n), .abb_le_n(abb_le_n), .a_in(a_in), .b_in(b_in), .ab_in(ab_in),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .ab_oe_n(ab_oe_n),
    .a_out(a_out1), .b_out(b_out1), .ab_out(ab_out1),
    .a_drv(a_drv1), .b_drv(b_drv1), .ab_drv(ab_drv1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_words(input string tag);
    chk({tag, " ab u0"}, ab_out0, sel_b ? m_b : m_a);
    chk({tag, " ab u1 R7"}, ab_out1, ~(sel_b ? m_b : m_a));
    chk({tag, " a u0 R5"}, a_out0, m_ba);
    chk({tag, " a u1 R7"}, a_out1, ~m_ba);
    chk({tag, " b u0 R5"}, b_out0, m_bb);
    chk({tag, " b u1 R7"}, b_out1, ~m_bb);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all-requirements act=timeout exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_b = '0; m_ba = '0; m_bb = '0;
    #1;
    chk_words("R1 reset");

    // R2 R3 R4 R5 R8: every enable combination, both selects
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      a_in  = 16'h1A2B ^ 16'(i * 16'h3717);
      b_in  = 16'hC4D5 ^ 16'(i * 16'h0F39);
      ab_in = 16'h6E7F ^ 16'(i * 16'h5A51);
      {abb_le_n, aba_le_n, b_le_n, a_le_n} = 4'(i) ^ 4'(i >> 4);
      sel_b = i[4];
      @(posedge clk);
      if (!a_le_n)   m_a  = a_in;
      if (!b_le_n)   m_b  = b_in;
      if (!aba_le_n) m_ba = ab_in;
      if (!abb_le_n) m_bb = ab_in;
      #1;
      chk_words((sel_b ? b_le_n : a_le_n) ? "R3 R8 hold" : "R2 R8 load");
      // R4: flip select without a clock
      @(negedge clk);
      a_le_n = 1'b1; b_le_n = 1'b1; aba_le_n = 1'b1; abb_le_n = 1'b1;
      a_in = ~a_in; b_in = ~b_in; ab_in = ~ab_in;
      sel_b = ~sel_b;
      #1;
      chk("R4 select u0", ab_out0, sel_b ? m_b : m_a);
      chk("R4 select u1 R7", ab_out1, ~(sel_b ? m_b : m_a));
      @(posedge clk);
      #1;
      chk_words("R3 ignored input");
    end

    // R6: all 64 byte-enable patterns
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      {ab_oe_n, b_oe_n, a_oe_n} = 6'(p);
      #1;
      chk("R6 a lanes", {14'd0, a_drv0}, {14'd0, ~a_oe_n});
      chk("R6 b lanes", {14'd0, b_drv0}, {14'd0, ~b_oe_n});
      chk("R6 ab lanes", {14'd0, ab_drv0}, {14'd0, ~ab_oe_n});
      chk("R6 ab lanes u1", {14'd0, ab_drv1}, {14'd0, ~ab_oe_n});
    end

    // R1: reset again after loading data
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    m_a = '0; m_b = '0; m_ba = '0; m_bb = '0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk_words("R1 mid-run reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule